// File: doc/BRIEF.md
# PHY Management Command Engine

This block is a clause 22 serial management master for an Ethernet PHY. Software controls it through one 32-bit register. A single write to that register carries the operation, the PHY address, the PHY register address and, for writes, the 16-bit data word. A write that also sets the start/busy bit launches a transaction. The engine then produces the complete management frame on the MDC clock and the MDIO data line. When the frame is finished it clears the busy bit and pulses a completion event.

For reads the engine releases MDIO from the turnaround onward. It checks that the PHY pulls the second turnaround bit low, then shifts in 16 data bits and places them in the low half of the same register. A PHY that does not answer sets a read-fail flag and raises the error event together with the completion event. MDC is derived from the system clock by a parameterised divider. MDIO changes only while MDC is low and is sampled at MDC rising edges.

Top module: `phy_mgmt_engine`

## Requirements
- R1: After reset the register reads 0, MDC is low, MDIO is released (output enable 0) and neither event is asserted; while busy is clear MDC stays low and MDIO stays released.
- R2: Register layout: bit 29 start/busy, bit 28 read-fail, bits 27:26 operation (1 = write, 2 = read), bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data. Bits 31:30 read 0. A write with bit 29 clear stores the fields and starts nothing.
- R3: A write transaction drives 64 bits, MSB first: 32 ones, 01, opcode 01, PHY address, register address, turnaround 10, then the 16 data bits. MDIO is enabled for all 64 bits.
- R4: A read transaction drives 32 ones, 01, opcode 10, PHY address and register address, then releases MDIO for bit positions 46 to 63. The data bits are sampled at MDC rising edges and returned in bits 15:0.
- R5: If MDIO is high at the rising edge of the second turnaround bit of a read, bit 28 is set and the error event pulses in the same cycle as the completion event.
- R6: A transaction ends exactly 64 MDC periods after the start write is accepted. Busy then clears, and the completion event is a single-cycle pulse in the first cycle that busy reads 0.
- R7: MDC has a period of 2*MDC_HALF system clocks during a transaction. MDIO output changes only while MDC is low.
- R8: Register writes while busy is set are ignored and leave the transaction and the stored fields unchanged.
- R9: A start with operation 0 or 3 produces no MDC edges. Busy clears one cycle after acceptance, and the completion and error events pulse together.
- R10: Every accepted register write clears the read-fail flag; software cannot set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the command register |
| reg_wr_data | input | 32 | Command register write value |
| reg_rd_data | output | 32 | Command register contents (busy, fail, fields, data) |
| done_pulse | output | 1 | One-cycle completion event |
| error_pulse | output | 1 | One-cycle error event (missing PHY answer or bad operation) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench targets the turnaround. A design that keeps driving during the turnaround, or that samples the wrong bit for the PHY answer, shows a wrong enable pattern or a missed or false read-fail. A command written mid-transaction checks R8: an engine that accepts it would corrupt the frame or the stored fields. Undefined operation codes check R9: an engine that treats them as reads or writes would toggle MDC and hang busy for a full frame. The transaction length and the read-back data word check the bit count and the sampling edge, because an off-by-one in either shifts the returned word.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_FIRST   = 46;
  localparam int TA_LAST    = 47;
  localparam int DATA_FIRST = 48;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_BAD   = 2'd3
  } mgmt_op_e;

  typedef struct packed {
    mgmt_op_e    op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } mgmt_cmd_t;

  function automatic logic op_valid(mgmt_op_e op);
    return (op == OP_WRITE) || (op == OP_READ);
  endfunction

  // Bit of the serial frame at position idx (0 = first on the wire).
  function automatic logic frame_bit(mgmt_cmd_t c, logic [IDX_W-1:0] idx);
    logic [FRAME_BITS-1:0] f;
    logic [IDX_W-1:0]      last;
    last = IDX_W'(FRAME_BITS - 1);
    f = {32'hFFFF_FFFF, 2'b01, (c.op == OP_READ) ? 2'b10 : 2'b01,
         c.phy, c.regad, 2'b10, c.data};
    return f[last - idx];
  endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int HALF = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick     = run && (cnt == CNT_END);
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_cmd_reg.sv
module mgmt_cmd_reg
  import phy_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        finish,
  input  logic        rd_done,
  input  logic        rd_fail,
  input  logic [15:0] rd_word,
  output logic        busy,
  output mgmt_cmd_t   cmd,
  output logic [31:0] rd_data
);
  logic fail;
  logic accept;
  logic unused_hi;

  assign unused_hi = ^wr_data[31:30];
  assign accept    = wr_en && !busy;
  assign rd_data   = {2'b00, busy, fail, cmd};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      fail <= 1'b0;
      cmd  <= '0;
    end else if (accept) begin
      cmd  <= mgmt_cmd_t'(wr_data[27:0]);
      busy <= wr_data[29];
      fail <= 1'b0;
    end else if (finish) begin
      busy <= 1'b0;
      if (rd_done) begin
        cmd.data <= rd_word;
        fail     <= rd_fail;
      end
    end
  end
endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
  import phy_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  mgmt_cmd_t        cmd,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             mdio_i,
  output logic             run,
  output logic [IDX_W-1:0] idx,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             finish,
  output logic             rd_done,
  output logic             rd_fail,
  output logic [15:0]      rd_word,
  output logic             err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA0_IDX  = IDX_W'(TA_FIRST);
  localparam logic [IDX_W-1:0] TA1_IDX  = IDX_W'(TA_LAST);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_FIRST);

  logic        is_read;
  logic        last;
  logic        ta_bad;
  logic [15:0] shreg;

  assign is_read = (cmd.op == OP_READ);
  assign run     = busy && op_valid(cmd.op);
  assign last    = (idx == LAST_IDX);
  assign finish  = (busy && !op_valid(cmd.op)) || (run && fall_evt && last);
  assign rd_done = finish && run && is_read;
  assign rd_fail = ta_bad;
  assign rd_word = shreg;
  assign err     = finish && (!run || (is_read && ta_bad));
  assign mdio_oe = run && (!is_read || (idx < TA0_IDX));
  assign mdio_o  = run ? frame_bit(cmd, idx) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      ta_bad <= 1'b0;
      shreg  <= '0;
    end else if (!run) begin
      idx    <= '0;
      ta_bad <= 1'b0;
    end else begin
      if (rise_evt && is_read) begin
        if (idx == TA1_IDX) ta_bad <= mdio_i;
        if (idx >= DAT_IDX) shreg <= {shreg[14:0], mdio_i};
      end
      if (fall_evt && !last) idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/phy_mgmt_engine.sv
module phy_mgmt_engine
  import phy_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wr_data,
  output logic [31:0] reg_rd_data,
  output logic        done_pulse,
  output logic        error_pulse,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic             busy;
  mgmt_cmd_t        cmd;
  logic             run;
  logic             rise_evt;
  logic             fall_evt;
  logic [IDX_W-1:0] frame_idx;
  logic             finish;
  logic             rd_done;
  logic             rd_fail;
  logic [15:0]      rd_word;
  logic             seq_err;

  mdc_divider #(.HALF(MDC_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mgmt_cmd_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .finish(finish), .rd_done(rd_done), .rd_fail(rd_fail), .rd_word(rd_word),
    .busy(busy), .cmd(cmd), .rd_data(reg_rd_data)
  );

  mgmt_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cmd(cmd),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_i(mdio_i),
    .run(run), .idx(frame_idx), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .finish(finish), .rd_done(rd_done), .rd_fail(rd_fail),
    .rd_word(rd_word), .err(seq_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_pulse  <= 1'b0;
      error_pulse <= 1'b0;
    end else begin
      done_pulse  <= finish;
      error_pulse <= seq_err;
    end
  end
endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker
  import phy_mgmt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [31:0]      reg_rd_data,
  input logic             done_pulse,
  input logic             error_pulse,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic [IDX_W-1:0] frame_idx,
  input logic             rise_evt
);
  logic busy;
  assign busy = reg_rd_data[29];

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R1

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (!busy && $past(busy))); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R6

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    error_pulse |-> done_pulse); // R5

  AST_MDIO_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> !mdc); // R7

  AST_MDC_RISE_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(rise_evt)); // R7

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr_en) |=> $stable(reg_rd_data[27:16])); // R8

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_rd_data[27:26] == 2'b10 && frame_idx >= IDX_W'(TA_FIRST)) |-> !mdio_oe); // R4
endmodule

bind phy_mgmt_engine phy_mgmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_data(reg_rd_data),
  .done_pulse(done_pulse), .error_pulse(error_pulse), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .frame_idx(frame_idx), .rise_evt(rise_evt)
);

// File: tb/tb_phy_mgmt_engine.sv
module tb_phy_mgmt_engine;
  localparam int HALF = 3;
  localparam int OP_CYCLES = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        done_pulse, error_pulse, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #2.5 clk = ~clk;

  phy_mgmt_engine #(.MDC_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .done_pulse(done_pulse), .error_pulse(error_pulse),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct {
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wdata;
    logic        answer;
    logic [15:0] rword;
    int          w_cyc;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic        phy_answer = 1'b0;
  logic [15:0] phy_word = '0;
  logic [63:0] cap_o, cap_oe;
  int rise_cnt = 0, fall_cnt = 0, total_rises = 0;
  logic mdc_prev = 1'b0, busy_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input exp_t e, input int i);
    if (i < 32) return 1'b1;
    case (i)
      32: return 1'b0;
      33: return 1'b1;
      34: return e.op == 2'd2;
      35: return e.op != 2'd2;
      46: return 1'b1;
      47: return 1'b0;
      default: ;
    endcase
    if (i <= 40) return e.phy[40 - i];
    if (i <= 45) return e.rg[45 - i];
    return e.wdata[63 - i];
  endfunction

  task automatic judge(input exp_t e);
    logic valid, is_rd, fail_x, err_x;
    logic [15:0] dat_x;
    logic [31:0] word_x;
    logic [63:0] oe_x, o_x;
    string rq;
    valid  = (e.op == 2'd1) || (e.op == 2'd2);
    is_rd  = (e.op == 2'd2);
    fail_x = is_rd && !e.answer;
    err_x  = fail_x || !valid;
    dat_x  = is_rd ? (e.answer ? e.rword : 16'hFFFF) : e.wdata;
    word_x = {2'b00, 1'b0, fail_x, e.op, e.phy, e.rg, dat_x};
    rq = is_rd ? "R4" : "R3";
    check((cyc - e.w_cyc) == (valid ? OP_CYCLES : 1), valid ? "R6" : "R9",
          "cycles to done", 64'(cyc - e.w_cyc), 64'(valid ? OP_CYCLES : 1));
    check(error_pulse == err_x, is_rd ? "R5" : "R9", "error event", 64'(error_pulse), 64'(err_x));
    check(reg_rd_data == word_x, rq, "register after done", 64'(reg_rd_data), 64'(word_x));
    if (!valid) begin
      check(rise_cnt == 0, "R9", "MDC rises for bad op", 64'(rise_cnt), 64'd0);
    end else begin
      oe_x = '0; o_x = '0;
      for (int i = 0; i < 64; i++) begin
        oe_x[i] = !is_rd || (i < 46);
        o_x[i]  = oe_x[i] ? exp_bit(e, i) : 1'b0;
      end
      check(rise_cnt == 64, "R6", "MDC periods", 64'(rise_cnt), 64'd64);
      check(cap_oe == oe_x, rq, "enable pattern", cap_oe, oe_x);
      check((cap_o & oe_x) == o_x, rq, "frame bits", cap_o & oe_x, o_x);
    end
  endtask

  // Monitor, PHY model and scoreboard, all sampled away from the active edge.
  always @(negedge clk) begin
    if (reg_rd_data[29] && !busy_prev) begin
      rise_cnt = 0; fall_cnt = 0; cap_o = '0; cap_oe = '0; mdio_i = 1'b1;
    end
    if (mdc && !mdc_prev) begin
      if (rise_cnt < 64) begin
        cap_o[rise_cnt]  = mdio_o;
        cap_oe[rise_cnt] = mdio_oe;
      end
      rise_cnt++; total_rises++;
    end
    if (!mdc && mdc_prev) begin
      fall_cnt++;
      if (phy_answer && fall_cnt == 47) mdio_i = 1'b0;
      else if (phy_answer && fall_cnt >= 48 && fall_cnt <= 63) mdio_i = phy_word[63 - fall_cnt];
      else mdio_i = 1'b1;
    end
    if (done_pulse) begin
      if (sb.size() == 0) check(1'b0, "R6", "unexpected done", 64'd1, 64'd0);
      else judge(sb.pop_front());
    end
    mdc_prev  = mdc;
    busy_prev = reg_rd_data[29];
  end

  task automatic write_raw(input logic [31:0] v, output int w);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = v;
    @(negedge clk); reg_wr_en = 1'b0; w = cyc;
  endtask

  task automatic issue(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic ans, input logic [15:0] rw);
    exp_t e;
    int w;
    phy_answer = ans; phy_word = rw;
    e.op = op; e.phy = phy; e.rg = rg; e.wdata = wd; e.answer = ans; e.rword = rw;
    write_raw({2'b00, 1'b1, 1'b0, op, phy, rg, wd}, w);
    e.w_cyc = w;
    sb.push_back(e);
  endtask

  task automatic wait_empty();
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int w, r0;
    repeat (5) @(negedge clk);
    check(reg_rd_data == 32'd0, "R1", "reset register", 64'(reg_rd_data), 64'd0);
    check(!mdc && !mdio_oe, "R1", "reset MDC/enable", {62'd0, mdc, mdio_oe}, 64'd0);
    check(!done_pulse && !error_pulse, "R1", "reset events", {62'd0, done_pulse, error_pulse}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    issue(2'd1, 5'h05, 5'h1A, 16'hA53C, 1'b0, 16'h0);      wait_empty(); // R3
    issue(2'd2, 5'h1F, 5'h00, 16'h0000, 1'b1, 16'h1234);   wait_empty(); // R4
    issue(2'd2, 5'h00, 5'h1F, 16'h0000, 1'b1, 16'h8001);   wait_empty(); // R4
    issue(2'd1, 5'h00, 5'h1F, 16'hFFFF, 1'b0, 16'h0);      wait_empty(); // R3
    issue(2'd2, 5'h11, 5'h02, 16'h0000, 1'b0, 16'h0);      wait_empty(); // R5

    // R2 and R10: write without start, attempting to set the fail bit.
    r0 = total_rises;
    write_raw({2'b11, 1'b0, 1'b1, 2'b01, 5'h0A, 5'h03, 16'h5555}, w);
    repeat (30) @(negedge clk);
    check(reg_rd_data == {2'b00, 1'b0, 1'b0, 2'b01, 5'h0A, 5'h03, 16'h5555}, "R2",
          "fields stored without start", 64'(reg_rd_data),
          64'({2'b00, 1'b0, 1'b0, 2'b01, 5'h0A, 5'h03, 16'h5555}));
    check(reg_rd_data[28] == 1'b0, "R10", "fail bit cleared by write", 64'(reg_rd_data[28]), 64'd0);
    check(total_rises == r0 && !mdc, "R2", "no MDC without start", 64'(total_rises - r0), 64'd0);

    // R8: command written while busy must be ignored.
    issue(2'd2, 5'h03, 5'h04, 16'h0000, 1'b1, 16'h0F0F);
    repeat (100) @(negedge clk);
    write_raw({2'b00, 1'b1, 1'b0, 2'b01, 5'h07, 5'h09, 16'h0000}, w);
    check(reg_rd_data[27:16] == {2'b10, 5'h03, 5'h04}, "R8", "fields during busy",
          64'(reg_rd_data[27:16]), 64'({2'b10, 5'h03, 5'h04}));
    wait_empty();
    check(reg_rd_data[27:0] == {2'b10, 5'h03, 5'h04, 16'h0F0F}, "R8", "fields after ignored write",
          64'(reg_rd_data[27:0]), 64'({2'b10, 5'h03, 5'h04, 16'h0F0F}));

    // R9: undefined operation codes.
    issue(2'd0, 5'h01, 5'h01, 16'h00AA, 1'b0, 16'h0); wait_empty();
    issue(2'd3, 5'h1E, 5'h1D, 16'h3C3C, 1'b0, 16'h0); wait_empty();

    issue(2'd1, 5'h15, 5'h0A, 16'h0001, 1'b0, 16'h0); wait_empty(); // R7 edges via frame
    finish_run();
  end
endmodule